// File: doc/BRIEF.md
# Frame-counting ring-buffer FIFO controller

This block runs one channel FIFO of a serial-link HDLC controller. Bytes sit in a byte-wide RAM used as a ring. An input pointer names the slot for the next stored byte and an output pointer names the slot for the next fetched byte. A second pair of ring counters counts whole frames, separately from bytes. The writer raises a strobe when a frame is fully stored. The reader raises a strobe when a frame is fully consumed. A full device uses six copies: a transmit and a receive FIFO for each of two bearer channels and one for the signalling channel.

The parameter `D_CHAN` selects the geometry. With the bearer geometry (`D_CHAN=0`), the byte pointers are 13 bits wide. They wrap from 1FFFh to 0200h, or to 1A00h while `mode_8k` is high. The frame counters are 5 bits wide and wrap from 1Fh to 00h. With the signalling geometry (`D_CHAN=1`), the byte pointers are 9 bits wide and wrap from 1FFh to 000h. The frame counters wrap from 1Fh to 10h, which leaves 16 frame slots.

The RAM sits inside the block. The pointers, the flags, the address of the last access and the read data are all registered outputs.

Top module: `hdlc_ring_fifo_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, `z1`, `z2`, `f1`, `f2` and `acc_addr` become all ones, `empty` becomes 1, and `full`, `frame_avail`, `frame_full` and `rd_data` become 0.
- R2: An accepted write stores `wr_data` at address `z1` and advances `z1` to its successor. An accepted read loads the byte at address `z2` into `rd_data` one clock later and advances `z2`. With no strobe, the pointers hold.
- R3: `full` is 1 exactly when the successor of `z1` equals `z2`. A write while `full` is 1 is ignored, even if a read is accepted in the same cycle: `z1` and the RAM keep their values.
- R4: A read while `empty` is 1 is ignored: `z2` and `rd_data` keep their values.
- R5: `empty` is 1 exactly when `z1` equals `z2`.
- R6: A write and a read in the same cycle, both accepted, advance both pointers. The flags then reflect the new pointer values.
- R7: In the bearer geometry with `mode_8k` low, the successor of 1FFFh is 0200h.
- R8: In the bearer geometry with `mode_8k` high, the successor of 1FFFh is 1A00h.
- R9: In the signalling geometry, the successor of 1FFh is 000h.
- R10: An accepted `eof_wr` advances `f1`, and an accepted `eof_rd` advances `f2`. `frame_avail` is 1 exactly when `f1` differs from `f2`.
- R11: The successor of frame count 1Fh is 00h in the bearer geometry and 10h in the signalling geometry.
- R12: `frame_full` is 1 exactly when the successor of `f1` equals `f2`. While it is 1, `eof_wr` is ignored. While `frame_avail` is 0, `eof_rd` is ignored.
- R13: After an accepted write, `acc_addr` holds the `z1` value used by that write. This includes cycles in which a read is also accepted. After a read-only access, `acc_addr` holds the `z2` value used. Otherwise `acc_addr` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (hardware or software) |
| mode_8k | input | 1 | Selects the 1A00h wrap base in the bearer geometry |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | DATA_W | Byte to store |
| rd_en | input | 1 | Byte read strobe |
| rd_data | output | DATA_W | Byte fetched by the last accepted read |
| eof_wr | input | 1 | A complete frame has been stored |
| eof_rd | input | 1 | A complete frame has been consumed |
| acc_addr | output | ZW | RAM address of the last accepted access |
| z1 | output | ZW | Byte input pointer |
| z2 | output | ZW | Byte output pointer |
| f1 | output | FW | Frame input counter |
| f2 | output | FW | Frame output counter |
| empty | output | 1 | No bytes stored |
| full | output | 1 | One more write would make the pointers meet |
| frame_avail | output | 1 | At least one complete frame is stored |
| frame_full | output | 1 | All frame slots are in use |

## Verification
The hardest states to reach are the wrap points and the full condition in the bearer geometry. Reaching them takes thousands of writes.

After reset the input pointer sits at the top of its range, so the first write crosses the wrap point at once. The stimulus then makes a long run of writes until the FIFO fills: 7679 bytes in normal mode and 1535 bytes in 8k mode. It checks that the write that follows is refused while a read in the same cycle is still taken. It then drains the FIFO past the wrap point of the output pointer.

The frame counters go through the same fill, refuse and drain sequence for both of their wrap rules.

// File: rtl/hdlc_fifo_pkg.sv
package hdlc_fifo_pkg;

  // Accepted-operation vector produced by the strobe gate.
  typedef struct packed {
    logic byte_wr;
    logic byte_rd;
    logic frm_in;
    logic frm_out;
  } fifo_ops_t;

  // Geometry constants for the two channel kinds.
  localparam int unsigned BEARER_ZW    = 13;
  localparam int unsigned SIGNAL_ZW    = 9;
  localparam int unsigned FRAME_W      = 5;
  localparam int unsigned BEARER_ZBASE = 32'h0200;
  localparam int unsigned BEARER_ZALT  = 32'h1A00;
  localparam int unsigned SIGNAL_ZBASE = 32'h0000;
  localparam int unsigned BEARER_FBASE = 32'h00;
  localparam int unsigned SIGNAL_FBASE = 32'h10;

  function automatic int unsigned ptr_width(input bit dchan);
    return dchan ? SIGNAL_ZW : BEARER_ZW;
  endfunction

endpackage

// File: rtl/hdlc_ring_ctr.sv
// Ring counter whose top value is all ones. It wraps to BASE_STD, or to
// BASE_ALT while alt is high, and resets to all ones. It also exposes its
// next value and the successor of that next value, so that flags can be
// registered from the coming state.
module hdlc_ring_ctr #(
  parameter int unsigned W = 9,
  parameter logic [W-1:0] BASE_STD = '0,
  parameter logic [W-1:0] BASE_ALT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         alt,
  input  logic         adv,
  output logic [W-1:0] q,
  output logic [W-1:0] nxt,
  output logic [W-1:0] nxt_succ
);

  function automatic logic [W-1:0] step(input logic [W-1:0] v, input logic a);
    if (v == '1) return a ? BASE_ALT : BASE_STD;
    return v + 1'b1;
  endfunction

  assign nxt      = adv ? step(q, alt) : q;
  assign nxt_succ = step(nxt, alt);

  always_ff @(posedge clk) begin
    if (rst) q <= '1;
    else     q <= nxt;
  end

endmodule

// File: rtl/hdlc_byte_ram.sv
// Simple dual-port RAM with a registered read port, written so that a
// block RAM can be inferred.
module hdlc_byte_ram #(
  parameter int unsigned AW = 9,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/hdlc_fifo_gate.sv
// Accepts or refuses the four strobes against the registered flags.
module hdlc_fifo_gate
  import hdlc_fifo_pkg::*;
(
  input  logic      wr_en,
  input  logic      rd_en,
  input  logic      eof_wr,
  input  logic      eof_rd,
  input  logic      full,
  input  logic      empty,
  input  logic      frame_full,
  input  logic      frame_avail,
  output fifo_ops_t ops
);

  always_comb begin
    ops.byte_wr = wr_en  & ~full;
    ops.byte_rd = rd_en  & ~empty;
    ops.frm_in  = eof_wr & ~frame_full;
    ops.frm_out = eof_rd &  frame_avail;
  end

endmodule

// File: rtl/hdlc_ring_fifo_ctrl.sv
module hdlc_ring_fifo_ctrl
  import hdlc_fifo_pkg::*;
#(
  parameter bit          D_CHAN = 1'b1,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ZW     = ptr_width(D_CHAN),
  parameter int unsigned FW     = FRAME_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_8k,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic              eof_wr,
  input  logic              eof_rd,
  output logic [ZW-1:0]     acc_addr,
  output logic [ZW-1:0]     z1,
  output logic [ZW-1:0]     z2,
  output logic [FW-1:0]     f1,
  output logic [FW-1:0]     f2,
  output logic              empty,
  output logic              full,
  output logic              frame_avail,
  output logic              frame_full
);

  localparam logic [ZW-1:0] Z_STD  = D_CHAN ? ZW'(SIGNAL_ZBASE) : ZW'(BEARER_ZBASE);
  localparam logic [ZW-1:0] Z_ALT  = D_CHAN ? ZW'(SIGNAL_ZBASE) : ZW'(BEARER_ZALT);
  localparam logic [FW-1:0] F_BASE = D_CHAN ? FW'(SIGNAL_FBASE) : FW'(BEARER_FBASE);

  fifo_ops_t ops;
  logic [ZW-1:0] z1_nxt, z1_nxt_succ, z2_nxt, z2_nxt_succ;
  logic [FW-1:0] f1_nxt, f1_nxt_succ, f2_nxt, f2_nxt_succ;
  logic alt_mode;

  // The 8k mode applies only to the bearer geometry.
  generate
    if (D_CHAN) begin : g_sig
      assign alt_mode = 1'b0;
    end else begin : g_bear
      assign alt_mode = mode_8k;
    end
  endgenerate

  hdlc_fifo_gate gate_i (
    .wr_en(wr_en), .rd_en(rd_en), .eof_wr(eof_wr), .eof_rd(eof_rd),
    .full(full), .empty(empty), .frame_full(frame_full),
    .frame_avail(frame_avail), .ops(ops)
  );

  hdlc_ring_ctr #(.W(ZW), .BASE_STD(Z_STD), .BASE_ALT(Z_ALT)) zin_i (
    .clk(clk), .rst(rst), .alt(alt_mode), .adv(ops.byte_wr),
    .q(z1), .nxt(z1_nxt), .nxt_succ(z1_nxt_succ)
  );

  hdlc_ring_ctr #(.W(ZW), .BASE_STD(Z_STD), .BASE_ALT(Z_ALT)) zout_i (
    .clk(clk), .rst(rst), .alt(alt_mode), .adv(ops.byte_rd),
    .q(z2), .nxt(z2_nxt), .nxt_succ(z2_nxt_succ)
  );

  hdlc_ring_ctr #(.W(FW), .BASE_STD(F_BASE), .BASE_ALT(F_BASE)) fin_i (
    .clk(clk), .rst(rst), .alt(1'b0), .adv(ops.frm_in),
    .q(f1), .nxt(f1_nxt), .nxt_succ(f1_nxt_succ)
  );

  hdlc_ring_ctr #(.W(FW), .BASE_STD(F_BASE), .BASE_ALT(F_BASE)) fout_i (
    .clk(clk), .rst(rst), .alt(1'b0), .adv(ops.frm_out),
    .q(f2), .nxt(f2_nxt), .nxt_succ(f2_nxt_succ)
  );

  hdlc_byte_ram #(.AW(ZW), .DW(DATA_W)) ram_i (
    .clk(clk), .rst(rst),
    .we(ops.byte_wr), .waddr(z1), .wdata(wr_data),
    .re(ops.byte_rd), .raddr(z2), .rdata(rd_data)
  );

  // Flags are registered from the coming pointer values.
  always_ff @(posedge clk) begin
    if (rst) begin
      empty       <= 1'b1;
      full        <= 1'b0;
      frame_avail <= 1'b0;
      frame_full  <= 1'b0;
    end else begin
      empty       <= (z1_nxt == z2_nxt);
      full        <= (z1_nxt_succ == z2_nxt);
      frame_avail <= (f1_nxt != f2_nxt);
      frame_full  <= (f1_nxt_succ == f2_nxt);
    end
  end

  // Address of the last accepted access; a write takes priority.
  always_ff @(posedge clk) begin
    if (rst)              acc_addr <= '1;
    else if (ops.byte_wr) acc_addr <= z1;
    else if (ops.byte_rd) acc_addr <= z2;
  end

  // f2_nxt_succ is produced by the shared counter but has no consumer.
  logic unused_ok;
  assign unused_ok = ^{f2_nxt_succ, z2_nxt_succ};

endmodule

// File: rtl/hdlc_ring_fifo_chk.sv
module hdlc_ring_fifo_chk #(
  parameter bit          D_CHAN = 1'b1,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ZW     = 9,
  parameter int unsigned FW     = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic              eof_wr,
  input logic              eof_rd,
  input logic [DATA_W-1:0] rd_data,
  input logic [ZW-1:0]     z1,
  input logic [ZW-1:0]     z2,
  input logic [FW-1:0]     f1,
  input logic [FW-1:0]     f2,
  input logic              empty,
  input logic              full,
  input logic              frame_avail,
  input logic              frame_full
);

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (z1 == '1 && z2 == '1 && f1 == '1 && f2 == '1 && empty && !full && !frame_avail));

  assert_z1_holds_R2: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(z1));

  assert_z2_holds_R2: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(z2));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    (full && wr_en) |=> $stable(z1));

  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (rst)
    (empty && rd_en) |=> ($stable(z2) && $stable(rd_data)));

  assert_empty_match_R5: assert property (@(posedge clk) disable iff (rst)
    empty == (z1 == z2));

  assert_both_move_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rd_en && !full && !empty) |=> (z1 != $past(z1) && z2 != $past(z2)));

  assert_frame_avail_R10: assert property (@(posedge clk) disable iff (rst)
    frame_avail == (f1 != f2));

  assert_frame_in_guard_R12: assert property (@(posedge clk) disable iff (rst)
    (frame_full && eof_wr) |=> $stable(f1));

  assert_frame_out_guard_R12: assert property (@(posedge clk) disable iff (rst)
    (!frame_avail && eof_rd) |=> $stable(f2));

  generate
    if (D_CHAN) begin : g_sig_slots
      assert_upper_slots_R11: assert property (@(posedge clk) disable iff (rst)
        (f1[FW-1] && f2[FW-1]));
    end
  endgenerate

endmodule

bind hdlc_ring_fifo_ctrl hdlc_ring_fifo_chk #(
  .D_CHAN(D_CHAN), .DATA_W(DATA_W), .ZW(ZW), .FW(FW)
) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .eof_wr(eof_wr),
  .eof_rd(eof_rd), .rd_data(rd_data), .z1(z1), .z2(z2), .f1(f1), .f2(f2),
  .empty(empty), .full(full), .frame_avail(frame_avail), .frame_full(frame_full)
);

// File: tb/hdlc_ring_fifo_ctrl_tb_top.sv
module hdlc_ring_fifo_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_8k = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, eof_wr = 1'b0, eof_rd = 1'b0;
  logic [7:0] wr_data = 8'h00;

  // Instance 0: signalling geometry (dut_i); instance 1: bearer geometry.
  logic [7:0]  rd_d, rd_b;
  logic [8:0]  acc_d, z1_d, z2_d;
  logic [12:0] acc_b, z1_b, z2_b;
  logic [4:0]  f1_d, f2_d, f1_b, f2_b;
  logic emp_d, ful_d, fav_d, ffu_d, emp_b, ful_b, fav_b, ffu_b;

  always #(CLK_PERIOD/2) clk = ~clk;

  hdlc_ring_fifo_ctrl #(.D_CHAN(1'b1)) dut_i (
    .clk(clk), .rst(rst), .mode_8k(mode_8k), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_d), .eof_wr(eof_wr), .eof_rd(eof_rd),
    .acc_addr(acc_d), .z1(z1_d), .z2(z2_d), .f1(f1_d), .f2(f2_d),
    .empty(emp_d), .full(ful_d), .frame_avail(fav_d), .frame_full(ffu_d));

  hdlc_ring_fifo_ctrl #(.D_CHAN(1'b0)) dutb_i (
    .clk(clk), .rst(rst), .mode_8k(mode_8k), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_b), .eof_wr(eof_wr), .eof_rd(eof_rd),
    .acc_addr(acc_b), .z1(z1_b), .z2(z2_b), .f1(f1_b), .f2(f2_b),
    .empty(emp_b), .full(ful_b), .frame_avail(fav_b), .frame_full(ffu_b));

  // ---------------- behavioural reference model ----------------
  int mz1[2], mz2[2], mf1[2], mf2[2], macc[2], mrd[2];
  bit memp[2], mful[2], mfav[2], mffu[2];
  int mem [int];
  int checks = 0, fails = 0;
  bit chk_on = 1'b0;
  string phase = "R1";

  function automatic int ztop(input int i);
    return (i == 0) ? 511 : 8191;
  endfunction

  function automatic int zsucc(input int i, input int v);
    if (v != ztop(i)) return v + 1;
    if (i == 0) return 0;
    return mode_8k ? 32'h1A00 : 32'h0200;
  endfunction

  function automatic int fsucc(input int i, input int v);
    if (v != 31) return v + 1;
    return (i == 0) ? 16 : 0;
  endfunction

  task automatic model_step(input int i);
    bit wok, rok, eok, fok;
    if (rst) begin
      mz1[i] = ztop(i); mz2[i] = ztop(i); mf1[i] = 31; mf2[i] = 31;
      macc[i] = ztop(i); mrd[i] = 0;
    end else begin
      wok = wr_en && !mful[i];
      rok = rd_en && !memp[i];
      eok = eof_wr && !mffu[i];
      fok = eof_rd && mfav[i];
      if (rok) mrd[i] = mem[i * 65536 + mz2[i]];
      if (wok) mem[i * 65536 + mz1[i]] = int'(wr_data);
      if (wok) macc[i] = mz1[i];
      else if (rok) macc[i] = mz2[i];
      if (wok) mz1[i] = zsucc(i, mz1[i]);
      if (rok) mz2[i] = zsucc(i, mz2[i]);
      if (eok) mf1[i] = fsucc(i, mf1[i]);
      if (fok) mf2[i] = fsucc(i, mf2[i]);
    end
    memp[i] = (mz1[i] == mz2[i]);
    mful[i] = (zsucc(i, mz1[i]) == mz2[i]);
    mfav[i] = (mf1[i] != mf2[i]);
    mffu[i] = (fsucc(i, mf1[i]) == mf2[i]);
  endtask

  always @(posedge clk) begin
    for (int i = 0; i < 2; i++) model_step(i);
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(phase, "z1 sig",  int'(z1_d), mz1[0]);
    chk(phase, "z2 sig",  int'(z2_d), mz2[0]);
    chk(phase, "f1 sig",  int'(f1_d), mf1[0]);
    chk(phase, "f2 sig",  int'(f2_d), mf2[0]);
    chk("R2",  "rd_data sig", int'(rd_d), mrd[0]);
    chk("R13", "acc_addr sig", int'(acc_d), macc[0]);
    chk("R5",  "empty sig", int'(emp_d), int'(memp[0]));
    chk("R3",  "full sig",  int'(ful_d), int'(mful[0]));
    chk("R10", "frame_avail sig", int'(fav_d), int'(mfav[0]));
    chk("R12", "frame_full sig",  int'(ffu_d), int'(mffu[0]));
    chk(phase, "z1 bear",  int'(z1_b), mz1[1]);
    chk(phase, "z2 bear",  int'(z2_b), mz2[1]);
    chk(phase, "f1 bear",  int'(f1_b), mf1[1]);
    chk(phase, "f2 bear",  int'(f2_b), mf2[1]);
    chk("R2",  "rd_data bear", int'(rd_b), mrd[1]);
    chk("R13", "acc_addr bear", int'(acc_b), macc[1]);
    chk("R5",  "empty bear", int'(emp_b), int'(memp[1]));
    chk("R3",  "full bear",  int'(ful_b), int'(mful[1]));
    chk("R10", "frame_avail bear", int'(fav_b), int'(mfav[1]));
    chk("R12", "frame_full bear",  int'(ffu_b), int'(mffu[1]));
  endtask

  always @(negedge clk) if (chk_on) compare_all();

  // ---------------- stimulus ----------------
  task automatic cyc(input bit w, input bit r, input bit ew, input bit er);
    @(negedge clk);
    wr_en = w; rd_en = r; eof_wr = ew; eof_rd = er;
    wr_data = wr_data + 8'd37;
  endtask

  task automatic do_reset(input bit m);
    @(negedge clk);
    phase = "R1"; rst = 1'b1; mode_8k = m;
    wr_en = 0; rd_en = 0; eof_wr = 0; eof_rd = 0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (2) @(posedge clk);
    chk_on = 1'b1;
    do_reset(1'b0);
    // R2: plain writes, then plain reads (first write crosses the wrap).
    phase = "R2";
    for (int k = 0; k < 6; k++) cyc(1, 0, 0, 0);
    for (int k = 0; k < 6; k++) cyc(0, 1, 0, 0);
    // R4: reads while empty.
    phase = "R4";
    for (int k = 0; k < 4; k++) cyc(0, 1, 0, 0);
    // R6: simultaneous write and read, plus mixed patterns.
    phase = "R6";
    for (int k = 0; k < 3; k++) cyc(1, 0, 0, 0);
    for (int k = 0; k < 20; k++) cyc(1, 1, 0, 0);
    for (int k = 0; k < 10; k++) cyc(k % 2 == 0, k % 3 == 0, 0, 0);
    // R10/R12/R11: frame counters fill, refuse, drain, wrap.
    phase = "R10";
    for (int k = 0; k < 3; k++) cyc(0, 0, 1, 0);
    for (int k = 0; k < 3; k++) cyc(0, 0, 0, 1);
    phase = "R12";
    for (int k = 0; k < 4; k++) cyc(0, 0, 0, 1);
    for (int k = 0; k < 40; k++) cyc(0, 0, 1, 0);
    phase = "R11";
    for (int k = 0; k < 40; k++) cyc(0, 0, 0, 1);
    for (int k = 0; k < 70; k++) cyc(0, 0, 1, k % 2 == 1);
    for (int k = 0; k < 70; k++) cyc(0, 0, k % 3 == 0, 1);
    // R9/R3: signalling FIFO fills and wraps; R13 checked throughout.
    phase = "R9";
    for (int k = 0; k < 600; k++) cyc(1, 0, 0, 0);
    phase = "R3";
    for (int k = 0; k < 5; k++) cyc(1, 1, 0, 0);
    phase = "R13";
    for (int k = 0; k < 700; k++) cyc(k % 5 == 0, 1, 0, 0);
    // R7: bearer geometry, normal mode, fill to full and drain.
    do_reset(1'b0);
    phase = "R7";
    for (int k = 0; k < 7700; k++) cyc(1, 0, 0, 0);
    for (int k = 0; k < 4; k++) cyc(1, 1, 0, 0);
    for (int k = 0; k < 7700; k++) cyc(0, 1, 0, 0);
    for (int k = 0; k < 300; k++) cyc(1, k % 2 == 1, 0, 0);
    // R8: bearer geometry, 8k mode.
    do_reset(1'b1);
    phase = "R8";
    for (int k = 0; k < 1600; k++) cyc(1, 0, 0, 0);
    for (int k = 0; k < 4; k++) cyc(1, 1, 0, 0);
    for (int k = 0; k < 1600; k++) cyc(0, 1, 0, 0);
    for (int k = 0; k < 3200; k++) cyc(1, k % 3 != 0, 0, 0);
    cyc(0, 0, 0, 0);
    @(negedge clk);
    summary();
  end

endmodule